// File: doc/BRIEF.md
# Sequential Radix-8 Booth Multiplier

This block multiplies two signed two's-complement operands over several clock cycles. Each cycle it retires three bits of the multiplier. The multiplier operand A is held in a register that sits below an accumulator, with one extra flag bit L below A. Together these three parts behave as one register that shifts right. In every iteration, the three low bits of A and the flag L select a signed multiple of the multiplicand B, in the range -4B to +4B. That multiple is added into the accumulator, and then the combined register shifts right arithmetically by three places.

The caller presents both operands together with a one-cycle `start_i`. The operands are accepted only while the block is idle. `busy_o` is high while the iterations run. `done_o` pulses high for one cycle when the signed product on `product_o` is ready. `WIDTH` must be a multiple of three. The accumulator is three bits wider than an operand, so that it can hold the largest multiples without overflow. The 3B multiple is formed once, when the operands are accepted, and is kept in a register.

Top module: `booth8_mul`

## Requirements
- R1: While rst_ni is low, and after it is released, busy_o=0, done_o=0 and product_o=0 until the first accepted start.
- R2: When start_i is high on a rising edge while the block is idle (busy_o=0), the block latches a_i and b_i, and busy_o is high from the following cycle.
- R3: The accumulator is WIDTH+3 bits wide and never overflows. This holds for the extreme operands, for example -256 x -256 = 65536 and -256 x 255 = -65280 at WIDTH=9.
- R4: In each iteration, the 4-bit group {A[2],A[1],A[0],L} selects a multiple of B equal to 2*A[1] + A[0] + L - 4*A[2]. Here A is the current multiplier register and L is the bit most recently shifted out of it (0 at start). The multiple therefore lies between -4B and +4B. After each add, the combined {accumulator, A, L} register shifts right arithmetically by 3.
- R5: product_o equals the signed product a_i*b_i as a 2*WIDTH-bit two's-complement value. It is formed from the low WIDTH accumulator bits followed by the final A register.
- R6: done_o goes high exactly WIDTH/3 cycles after the accepting edge, and stays high for exactly one cycle. busy_o is low in the done cycle.
- R7: A start_i that arrives while busy_o=1 is ignored. The running product and its timing are unaffected.
- R8: While the block is idle and start_i is low, product_o holds its last value, regardless of a_i and b_i.
- R9: busy_o stays high for exactly WIDTH/3 consecutive cycles per accepted start.
- R10: A start_i that is high during the done cycle is accepted, so that products can be issued back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to multiply; sampled only while idle |
| a_i | input | WIDTH | Multiplier operand, signed |
| b_i | input | WIDTH | Multiplicand operand, signed |
| busy_o | output | 1 | High while iterations run |
| done_o | output | 1 | One-cycle pulse: product_o is valid |
| product_o | output | 2*WIDTH | Signed product |

## Verification
The bench drives start_i at one edge, calling it edge k. It then expects busy_o to be high just after edge k, and expects busy_o to be high with done_o low just after edges k+1 and k+2. It expects done_o to be high, busy_o low and the product correct just after edge k+3, which is k+WIDTH/3. Outputs are sampled 1 ns after each rising edge, and inputs are changed at the same moment. Each sample therefore reflects exactly the registers updated at that edge.

The bench checks every multiplier value against several multiplicands, so that all sixteen recoding groups are covered. It also runs all pairs of the corner values and a set of random pairs, issued back to back in the done cycle. The bench checks that product_o holds during idle cycles in which the operand inputs toggle. It also checks that a start raised mid-run changes neither the result nor the timing.

// File: rtl/booth8_pkg.sv
package booth8_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mul_state_e;

  localparam int unsigned GROUP_BITS = 3;  // multiplier bits retired per iteration
endpackage

// File: rtl/booth8_recode.sv
// Turns {a2,a1,a0,l} into a magnitude 0..4 and a sign.
module booth8_recode (
  input  logic [3:0] grp_i,
  output logic [2:0] mag_o,
  output logic       neg_o
);
  logic [2:0] pos;

  // Weight without the sign bit: 2*a1 + a0 + l, range 0..4
  assign pos = {1'b0, grp_i[2], 1'b0} + {2'b00, grp_i[1]} + {2'b00, grp_i[0]};

  always_comb begin
    if (grp_i[3]) begin
      mag_o = 3'd4 - pos;
      neg_o = (pos != 3'd4);
    end else begin
      mag_o = pos;
      neg_o = 1'b0;
    end
  end
endmodule

// File: rtl/booth8_multiples.sv
// Selects k*B, k in 0..4, and applies the sign in two's complement.
module booth8_multiples #(
  parameter int unsigned ACC_W = 12
) (
  input  logic [ACC_W-1:0] bx_i,   // B, sign-extended
  input  logic [ACC_W-1:0] b3_i,   // 3B, precomputed
  input  logic [2:0]       mag_i,
  input  logic             neg_i,
  output logic [ACC_W-1:0] term_o
);
  localparam int unsigned NUM_MULT = 5;

  logic [ACC_W-1:0] cand [NUM_MULT];
  logic [ACC_W-1:0] pick;

  for (genvar k = 0; k < NUM_MULT; k++) begin : g_cand
    if (k == 0) begin : g_zero
      assign cand[k] = '0;
    end else if (k == 3) begin : g_odd
      assign cand[k] = b3_i;
    end else begin : g_pow2
      assign cand[k] = bx_i << $clog2(k);
    end
  end

  always_comb begin
    pick = '0;
    for (int i = 0; i < NUM_MULT; i++) begin
      if (mag_i == 3'(i)) pick = cand[i];
    end
  end

  assign term_o = neg_i ? (~pick + ACC_W'(1)) : pick;
endmodule

// File: rtl/booth8_datapath.sv
module booth8_datapath #(
  parameter int unsigned WIDTH = 9,
  parameter int unsigned ACC_W = WIDTH + 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               step_i,
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   b_i,
  output logic [ACC_W-1:0]   acc_o,
  output logic [ACC_W-1:0]   term_o,
  output logic [ACC_W-1:0]   sum_o,
  output logic [2*WIDTH-1:0] product_o
);
  import booth8_pkg::*;

  localparam int unsigned EXT = ACC_W - WIDTH;
  localparam int unsigned SH  = GROUP_BITS;

  logic [ACC_W-1:0] acc_q, bx_q, b3_q;
  logic [WIDTH-1:0] mpl_q;
  logic             last_q;

  logic [ACC_W-1:0] bx_in, b3_in;
  logic [2:0]       mag;
  logic             neg;

  assign bx_in = {{EXT{b_i[WIDTH-1]}}, b_i};
  assign b3_in = bx_in + (bx_in << 1);

  booth8_recode u_recode (
    .grp_i ({mpl_q[2:0], last_q}),
    .mag_o (mag),
    .neg_o (neg)
  );

  booth8_multiples #(.ACC_W(ACC_W)) u_mult (
    .bx_i   (bx_q),
    .b3_i   (b3_q),
    .mag_i  (mag),
    .neg_i  (neg),
    .term_o (term_o)
  );

  assign sum_o = acc_q + term_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      mpl_q  <= '0;
      last_q <= 1'b0;
      bx_q   <= '0;
      b3_q   <= '0;
    end else if (load_i) begin
      acc_q  <= '0;
      mpl_q  <= a_i;
      last_q <= 1'b0;
      bx_q   <= bx_in;
      b3_q   <= b3_in;
    end else if (step_i) begin
      // {acc, mpl, last} as one register, arithmetic shift right by SH
      acc_q  <= {{SH{sum_o[ACC_W-1]}}, sum_o[ACC_W-1:SH]};
      mpl_q  <= {sum_o[SH-1:0], mpl_q[WIDTH-1:SH]};
      last_q <= mpl_q[SH-1];
    end
  end

  assign acc_o     = acc_q;
  assign product_o = {acc_q[WIDTH-1:0], mpl_q};
endmodule

// File: rtl/booth8_ctrl.sv
module booth8_ctrl #(
  parameter int unsigned ITER = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  import booth8_pkg::*;

  localparam int unsigned CNT_W = (ITER > 1) ? $clog2(ITER) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ITER - 1);

  mul_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  assign load_o = (state_q == ST_IDLE) && start_i;
  assign step_o = (state_q == ST_RUN);
  assign busy_o = step_o;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
          end
        end
        ST_RUN: begin
          if (cnt_q == LAST) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/booth8_mul.sv
module booth8_mul #(
  parameter int unsigned WIDTH = 9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   b_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [2*WIDTH-1:0] product_o
);
  import booth8_pkg::*;

  localparam int unsigned ITER  = WIDTH / GROUP_BITS;
  localparam int unsigned ACC_W = WIDTH + 3;

  logic             load, step;
  logic [ACC_W-1:0] acc, term, sum;

  booth8_ctrl #(.ITER(ITER)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  booth8_datapath #(.WIDTH(WIDTH), .ACC_W(ACC_W)) u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .step_i    (step),
    .a_i       (a_i),
    .b_i       (b_i),
    .acc_o     (acc),
    .term_o    (term),
    .sum_o     (sum),
    .product_o (product_o)
  );
endmodule

// File: rtl/booth8_mul_chk.sv
module booth8_mul_chk #(
  parameter int unsigned WIDTH = 9
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               busy_o,
  input logic               done_o,
  input logic [2*WIDTH-1:0] product_o,
  input logic [WIDTH+2:0]   acc,
  input logic [WIDTH+2:0]   term,
  input logic [WIDTH+2:0]   sum
);
  localparam int unsigned ITER  = WIDTH / 3;
  localparam int unsigned MSB   = WIDTH + 2;
  localparam int unsigned RUN_W = $clog2(ITER + 1) + 1;

  logic [RUN_W-1:0] run_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_len_q <= '0;
    else if (busy_o) run_len_q <= run_len_q + RUN_W'(1);
    else             run_len_q <= '0;
  end

  // R3: equal-sign operands never give a result of the other sign
  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && (acc[MSB] == term[MSB])) |-> (sum[MSB] == acc[MSB]));

  a_r2_start_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);

  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r6_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r9_busy_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (run_len_q == RUN_W'(ITER)));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(product_o));

  a_r7_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && (run_len_q < RUN_W'(ITER - 1))) |=> busy_o);
endmodule

bind booth8_mul booth8_mul_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .product_o (product_o),
  .acc       (acc),
  .term      (term),
  .sum       (sum)
);

// File: tb/booth8_mul_test.sv
`timescale 1ns/1ps
module booth8_mul_test;
  localparam int W    = 9;
  localparam int ITER = W / 3;
  localparam int PW   = 2 * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  a = '0, b = '0;
  logic          busy, done;
  logic [PW-1:0] prod;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  booth8_mul #(.WIDTH(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .a_i(a), .b_i(b),
    .busy_o(busy), .done_o(done), .product_o(prod)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sprod();
    return int'($signed(prod));
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Issue one multiply; returns right after the done edge (done cycle).
  task automatic run_mul(input int av, input int bv, input string req);
    int exp = av * bv;
    start = 1'b1;
    a = W'(av);
    b = W'(bv);
    tick();
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    for (int i = 1; i <= ITER; i++) begin
      tick();
      if (i < ITER) begin
        chk(done == 1'b0 && busy == 1'b1, "R9 busy run", int'({busy, done}), 2);
      end else begin
        chk(done == 1'b1 && busy == 1'b0, "R6 done timing", int'({busy, done}), 1);
        chk(sprod() == exp, req, sprod(), exp);
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    chk(busy == 1'b0 && done == 1'b0 && prod == '0, "R1 in reset", int'(prod), 0);
    rst_n = 1'b1;
    repeat (2) tick();
    chk(busy == 1'b0 && done == 1'b0 && prod == '0, "R1 after reset", int'(prod), 0);
  endtask

  // All multiplier values cover every recode group {A2,A1,A0,L}
  task automatic t_r4_sweep();
    int bs[5] = '{-256, 255, -1, 1, 93};
    foreach (bs[j]) begin
      for (int av = -256; av < 256; av++) run_mul(av, bs[j], "R4 recode sweep");
    end
  endtask

  task automatic t_r3_corners();
    int cv[10] = '{-256, -255, -128, -1, 0, 1, 2, 127, 254, 255};
    foreach (cv[i]) begin
      foreach (cv[j]) run_mul(cv[i], cv[j], "R3 R5 corner product");
    end
  endtask

  task automatic t_r5_random();
    for (int n = 0; n < 300; n++) begin
      int av = int'($urandom_range(511)) - 256;
      int bv = int'($urandom_range(511)) - 256;
      run_mul(av, bv, "R5 random product");
    end
  endtask

  task automatic t_r7_start_ignored();
    int exp = -7 * -5;
    tick();
    start = 1'b1;
    a = W'(-7);
    b = W'(-5);
    tick();
    a = W'(100);
    b = W'(-100);
    for (int i = 1; i <= ITER; i++) begin
      if (i == ITER) start = 1'b0;
      tick();
      if (i < ITER) begin
        chk(busy == 1'b1 && done == 1'b0, "R7 run not restarted", int'({busy, done}), 2);
      end else begin
        chk(done == 1'b1, "R7 done on schedule", int'(done), 1);
        chk(sprod() == exp, "R7 product of first operands", sprod(), exp);
      end
    end
    start = 1'b0;
  endtask

  task automatic t_r8_hold();
    int held;
    run_mul(-256, -256, "R3 extreme product");
    held = sprod();
    chk(held == 65536, "R3 -256*-256", held, 65536);
    for (int i = 0; i < 5; i++) begin
      a = W'(i * 37);
      b = W'(-i * 51);
      tick();
      chk(sprod() == held && done == 1'b0 && busy == 1'b0, "R8 hold when idle", sprod(), held);
    end
  endtask

  task automatic t_r10_back_to_back();
    run_mul(255, -256, "R10 first of pair");
    run_mul(-3, 85, "R10 issued in done cycle");
    run_mul(0, -256, "R10 third");
    start = 1'b0;
    tick();
  endtask

  initial begin
    #5_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_r7_start_ignored();
    t_r8_hold();
    t_r10_back_to_back();
    t_r3_corners();
    start = 1'b0;
    tick();
    t_r4_sweep();
    start = 1'b0;
    tick();
    t_r5_random();
    start = 1'b0;
    tick();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule